// File: doc/BRIEF.md
# DMA Channel Request Selector

This block is the request front end of one DMA channel. It picks one line out of a vector of peripheral request inputs and passes it on as a single qualified request to the transfer scheduler. The request carries two tags. The first says which port it paces: the read port or the write port. The second says how the peripheral handshakes: once per burst or once per block. When the scheduler reports that it has finished a burst, the block sends a one-cycle acknowledge back to the selected peripheral. In block handshake mode it does this only for the burst that ends the block.

A software-request mode serves memory-to-memory transfers. In that mode the block flags a software request, and the hardware path stays idle: the index, the port tag and the granularity tag all have no effect. The configuration is captured at the moment the channel is enabled and is held until the channel is disabled. If two channels are given the same request index, the block neither detects nor reports it.

Top module: `dma_req_sel`

## Requirements
- R1: While rst_ni is low, req_o, sw_req_o, port_wr_o and blk_mode_o are 0 and ack_o is all zeros.
- R2: The configuration inputs are captured at the first clock edge at which en_i is sampled high after being low. Changes to them while en_i stays high have no effect on any output.
- R3: In hardware mode (software flag 0), req_o at each edge equals req_i[index] as sampled at that edge, provided en_i was high at that edge and at the one before.
- R4: An index of NUM_REQ or more selects no input. req_o stays 0 and ack_o stays all zeros.
- R5: While the channel is enabled in software mode (software flag 1), sw_req_o is 1. req_o, port_wr_o and blk_mode_o are 0 and ack_o is all zeros, whatever the index, the other flags and req_i are.
- R6: In hardware mode, port_wr_o shows the captured destination flag: 0 means the request paces the read port, 1 means it paces the write port.
- R7: In hardware mode, blk_mode_o shows the captured block flag: 0 means per-burst handshake, 1 means per-block handshake.
- R8: In burst handshake mode, when burst_done_i is high at an edge while the channel is enabled in hardware mode, ack_o[index] is 1 for exactly the following cycle and every other bit of ack_o is 0.
- R9: In block handshake mode, ack_o pulses as in R8 only when last_burst_i is high together with burst_done_i. Otherwise it stays all zeros.
- R10: After an edge at which en_i is sampled low, req_o, sw_req_o, port_wr_o and blk_mode_o are 0 and ack_o is all zeros. No pending request survives the disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| cfg_sel_i | input | 6 | Hardware request index |
| cfg_sw_i | input | 1 | Software-request (memory-to-memory) flag |
| cfg_dst_i | input | 1 | 1: request paces write port, 0: read port |
| cfg_blk_i | input | 1 | 1: per-block handshake, 0: per-burst |
| req_i | input | NUM_REQ | Peripheral request lines |
| burst_done_i | input | 1 | Scheduler finished a burst for this channel |
| last_burst_i | input | 1 | That burst ends the block |
| req_o | output | 1 | Qualified hardware request |
| sw_req_o | output | 1 | Software request active |
| port_wr_o | output | 1 | Port tag of req_o |
| blk_mode_o | output | 1 | Granularity tag of req_o |
| ack_o | output | NUM_REQ | One-hot acknowledge to the selected peripheral |

## Verification
Two functions can act in the same cycle: request sampling and acknowledge generation. This happens when the scheduler reports a burst while the selected peripheral is still raising its request. The bench provokes this on every configuration by holding all request lines high during the burst_done_i and last_burst_i pulses. In the following cycle it checks req_o and ack_o against values it computes from the index, the software flag and the block flag. The sweep covers all 64 index values (most of them beyond the eight implemented inputs) against every combination of the three flags. The configuration inputs are inverted while the channel is enabled, which shows that the captured configuration alone decides each result.

// File: rtl/dma_req_sel_pkg.sv
package dma_req_sel_pkg;
  localparam int SEL_W = 6;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             sw;
    logic             dst;
    logic             blk;
  } ch_cfg_t;
endpackage

// File: rtl/dma_req_cfg_latch.sv
module dma_req_cfg_latch
  import dma_req_sel_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  ch_cfg_t cfg_i,
  output logic    act_o,
  output ch_cfg_t cfg_o
);
  logic    act_q;
  ch_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      act_q <= en_i;
      if (en_i && !act_q) cfg_q <= cfg_i;
    end
  end

  assign act_o = act_q;
  assign cfg_o = cfg_q;

  // configuration frozen while the channel stays enabled
  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && en_i) |=> $stable(cfg_q));
endmodule

// File: rtl/dma_req_decode.sv
module dma_req_decode
  import dma_req_sel_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_REQ-1:0] dec_o
);
  localparam logic [SEL_W:0] NUM_W = (SEL_W+1)'(NUM_REQ);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_dec
    assign dec_o[g] = (sel_i == SEL_W'(g));
  end

  always_comb begin
    assert_dec_range_R4: assert (({1'b0, sel_i} < NUM_W) || (dec_o == '0));
    assert_dec_onehot_R8: assert ($onehot0(dec_o));
  end
endmodule

// File: rtl/dma_req_ack_gen.sv
module dma_req_ack_gen #(
  parameter int NUM_REQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               live_i,
  input  logic               blk_i,
  input  logic               done_i,
  input  logic               last_i,
  input  logic [NUM_REQ-1:0] dec_i,
  output logic [NUM_REQ-1:0] ack_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= live_i && done_i && (!blk_i || last_i);
  end

  assign ack_o = ack_q ? dec_i : '0;

  assert_burst_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_i && done_i && !blk_i) |=> ack_q);
  assert_block_ack_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && blk_i) |-> $past(last_i));
  assert_ack_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));
endmodule

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_req_sel_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic               cfg_sw_i,
  input  logic               cfg_dst_i,
  input  logic               cfg_blk_i,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               burst_done_i,
  input  logic               last_burst_i,
  output logic               req_o,
  output logic               sw_req_o,
  output logic               port_wr_o,
  output logic               blk_mode_o,
  output logic [NUM_REQ-1:0] ack_o
);
  ch_cfg_t              cfg_in, cfg;
  logic                 act;
  logic [NUM_REQ-1:0]   dec;
  logic                 hit, hw_act, live, req_q;

  assign cfg_in = '{sel: cfg_sel_i, sw: cfg_sw_i, dst: cfg_dst_i, blk: cfg_blk_i};

  dma_req_cfg_latch i_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .cfg_i (cfg_in),
    .act_o (act),
    .cfg_o (cfg)
  );

  dma_req_decode #(.NUM_REQ(NUM_REQ)) i_dec (
    .sel_i(cfg.sel),
    .dec_o(dec)
  );

  assign hit    = |(req_i & dec);
  assign hw_act = act && !cfg.sw;
  assign live   = hw_act && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= live && hit;
  end

  dma_req_ack_gen #(.NUM_REQ(NUM_REQ)) i_ack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .live_i(live),
    .blk_i (cfg.blk),
    .done_i(burst_done_i),
    .last_i(last_burst_i),
    .dec_i (dec),
    .ack_o (ack_o)
  );

  assign req_o      = req_q;
  assign sw_req_o   = act && cfg.sw;
  assign port_wr_o  = hw_act && cfg.dst;
  assign blk_mode_o = hw_act && cfg.blk;

  assert_sw_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_o |-> (!req_o && !port_wr_o && !blk_mode_o && (ack_o == '0)));
  assert_disable_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!req_o && !sw_req_o && !port_wr_o && !blk_mode_o && (ack_o == '0)));
  assert_req_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(en_i));
endmodule

// File: tb/test_dma_req_sel.sv
module test_dma_req_sel;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en, sw, dst, blk, done, last;
  logic [5:0]    sel;
  logic [NR-1:0] req;
  logic          req_o, sw_req_o, port_wr_o, blk_mode_o;
  logic [NR-1:0] ack_o;
  int            total = 0;
  int            bad = 0;

  always #5 clk = ~clk;

  dma_req_sel #(.NUM_REQ(NR)) i_dma_req_sel (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .cfg_sel_i(sel), .cfg_sw_i(sw), .cfg_dst_i(dst), .cfg_blk_i(blk),
    .req_i(req), .burst_done_i(done), .last_burst_i(last),
    .req_o(req_o), .sw_req_o(sw_req_o), .port_wr_o(port_wr_o),
    .blk_mode_o(blk_mode_o), .ack_o(ack_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    en = 0; sw = 0; dst = 0; blk = 0; done = 0; last = 0; sel = '0; req = '1;
    #3;
    // R1 reset state
    chk("R1 flags", 16'({req_o, sw_req_o, port_wr_o, blk_mode_o}), 16'h0);
    chk("R1 ack", 16'(ack_o), 16'h0);
    step; step;
    rst_ni = 1'b1;
    step;
    for (int c = 0; c < 512; c++) begin
      logic       e_sw, e_dst, e_blk, hw, inr;
      logic [5:0] e_sel;
      logic [NR-1:0] bitv;
      e_sel = c[5:0]; e_sw = c[6]; e_dst = c[7]; e_blk = c[8];
      hw  = !e_sw;
      inr = (e_sel < 6'(NR));
      bitv = inr ? (NR'(1) << e_sel[2:0]) : '0;

      en = 0; req = '0; step;
      sel = e_sel; sw = e_sw; dst = e_dst; blk = e_blk; en = 1;
      step;
      // R5 R6 R7 flags after enable capture
      chk("R5 sw_req", 16'(sw_req_o), 16'(e_sw));
      chk("R6 port_wr", 16'(port_wr_o), 16'(hw & e_dst));
      chk("R7 blk_mode", 16'(blk_mode_o), 16'(hw & e_blk));
      // R2: invert config while enabled, it must be ignored
      sel = ~e_sel; sw = ~e_sw; dst = ~e_dst; blk = ~e_blk;
      req = '1;
      step;
      chk("R3 R4 req hit", 16'(req_o), 16'(hw & inr));
      chk("R2 flags held", 16'({sw_req_o, port_wr_o, blk_mode_o}),
          16'({e_sw, hw & e_dst, hw & e_blk}));
      req = ~bitv;
      step;
      chk("R3 req miss", 16'(req_o), 16'h0);
      // coincident request sampling and burst acknowledge
      req = '1; done = 1; last = 0;
      step;
      done = 0;
      chk("R8 R9 burst ack", 16'(ack_o), 16'((hw && !e_blk) ? bitv : '0));
      chk("R3 req with ack", 16'(req_o), 16'(hw & inr));
      step;
      chk("R8 ack one cycle", 16'(ack_o), 16'h0);
      done = 1; last = 1;
      step;
      done = 0; last = 0;
      chk("R8 R9 last ack", 16'(ack_o), 16'(hw ? bitv : '0));
      en = 0; done = 1;
      step;
      done = 0;
      chk("R10 off flags", 16'({req_o, sw_req_o, port_wr_o, blk_mode_o}), 16'h0);
      chk("R10 off ack", 16'(ack_o), 16'h0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule